// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit carries out the three control-and-status-register instructions of a RISC-V-style core: swap (write the source value), bit-set and bit-clear. A request names a 12-bit register address, the source operand, whether the source register index is zero, and the privilege the hart is running at. The unit judges legality from the address alone. The top two address bits mark a register as read-only, and the next two bits give the lowest privilege allowed to touch it. The request is also illegal when the external register file reports the address as unimplemented, or when the operation code is not one of the three.

The register file sits outside the unit. The unit presents the request address on a read port and receives the current contents and a hit flag in the same cycle. One clock later it registers four results: the old value for the destination register, a write strobe with the address and the merged data, and an illegal-instruction flag. A set or clear whose source register index is zero is a pure read. It never writes, so it may target a read-only register.

Top module: `csr_rmw_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `rsp_valid`, `wr_en`, `illegal`, `rd_value`, `wr_addr` and `wr_data` are all zero.
- R2: Each request with `req_valid` high is answered exactly one clock later with `rsp_valid` high. In a cycle that follows no request, `rsp_valid`, `wr_en` and `illegal` are low.
- R3: Privilege is encoded U=0, S=1, M=3. A request is illegal when `cur_priv` is numerically below `req_addr[9:8]`.
- R4: When `req_addr[11:10]` is 2'b11, a request that counts as a write is illegal. A set or clear with `rs1_is_zero` high is still allowed.
- R5: Operation code 2'b01 (swap) always counts as a write. When legal, it writes `rs1_data` unchanged.
- R6: Operation code 2'b10 (set) writes old OR source. Operation code 2'b11 (clear) writes old AND NOT source. Each writes only when `rs1_is_zero` is low.
- R7: A set or clear with `rs1_is_zero` high leaves `wr_en` low and still returns the old value.
- R8: On a legal request, `rd_value` equals `csr_rd_data` as sampled in the request cycle, which is the contents before any write.
- R9: A request whose `csr_rd_hit` is low (unimplemented address) is illegal.
- R10: Whenever `illegal` is high, `wr_en` is low and `rd_value` is zero.
- R11: Operation code 2'b00 is illegal.
- R12: When `wr_en` is high, `wr_addr` equals the address of the request that caused the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 none, 01 swap, 10 set, 11 clear |
| req_addr | input | 12 | CSR address |
| rs1_data | input | XLEN | Source operand |
| rs1_is_zero | input | 1 | Source register index is zero |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| csr_rd_addr | output | 12 | Address for the external read port |
| csr_rd_data | input | XLEN | Current contents of the addressed CSR |
| csr_rd_hit | input | 1 | Addressed CSR is implemented |
| rsp_valid | output | 1 | Response present |
| rd_value | output | XLEN | Old CSR value for the destination register |
| wr_en | output | 1 | Write strobe to the CSR storage |
| wr_addr | output | 12 | Write address |
| wr_data | output | XLEN | Merged write data |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The three operations are applied to a machine-level register with old and source values that overlap in some bits and differ in others. This shows whether each merge is OR, AND-NOT or a plain copy. Set and clear are repeated with the zero-index flag high, which shows that write intent depends on that flag and not on the operand value. The same read-only and privilege-tagged addresses are accessed at U, S and M levels, and as pure reads and as writes, so the bench can tell whether the privilege compare and the read-only check are each applied. Unimplemented addresses, the unused operation code, and idle cycles between requests complete the set.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [1:0] RO_TAG = 2'b11;
    localparam int unsigned ADDR_W = 12;
endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
    import csr_rmw_pkg::*;
(
    input  csr_op_e    op,
    input  logic [3:0] addr_hi,
    input  logic       src_zero,
    input  logic [1:0] priv,
    input  logic       hit,
    output logic       wants_write,
    output logic       illegal
);
    logic [1:0] min_priv;
    logic       read_only;
    logic       bad_op;

    always_comb begin
        min_priv    = addr_hi[1:0];
        read_only   = (addr_hi[3:2] == RO_TAG);
        bad_op      = (op == OP_NONE);
        wants_write = (op == OP_SWAP) || (((op == OP_SET) || (op == OP_CLR)) && !src_zero);
        illegal     = bad_op || !hit || (priv < min_priv) || (read_only && wants_write);
    end
endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
    import csr_rmw_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  csr_op_e           op,
    input  logic [XLEN-1:0]   old_val,
    input  logic [XLEN-1:0]   src,
    output logic [XLEN-1:0]   new_val
);
    always_comb begin
        unique case (op)
            OP_SWAP: new_val = src;
            OP_SET:  new_val = old_val | src;
            OP_CLR:  new_val = old_val & ~src;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [XLEN-1:0]      rs1_data,
    input  logic                 rs1_is_zero,
    input  logic [1:0]           cur_priv,
    output logic [ADDR_W-1:0]    csr_rd_addr,
    input  logic [XLEN-1:0]      csr_rd_data,
    input  logic                 csr_rd_hit,
    output logic                 rsp_valid,
    output logic [XLEN-1:0]      rd_value,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [XLEN-1:0]      wr_data,
    output logic                 illegal
);
    typedef struct packed {
        logic                valid;
        logic [XLEN-1:0]     rd_value;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [XLEN-1:0]     wr_data;
        logic                illegal;
    } rsp_t;

    rsp_t    rsp_d, rsp_q;
    csr_op_e op_dec;
    logic    wants_write;
    logic    chk_illegal;
    logic [XLEN-1:0] merged;

    assign op_dec      = csr_op_e'(req_op);
    assign csr_rd_addr = req_addr;

    csr_access_check u_check (
        .op          (op_dec),
        .addr_hi     (req_addr[11:8]),
        .src_zero    (rs1_is_zero),
        .priv        (cur_priv),
        .hit         (csr_rd_hit),
        .wants_write (wants_write),
        .illegal     (chk_illegal)
    );

    csr_rmw_alu #(.XLEN(XLEN)) u_alu (
        .op      (op_dec),
        .old_val (csr_rd_data),
        .src     (rs1_data),
        .new_val (merged)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid   = 1'b1;
            rsp_d.illegal = chk_illegal;
            if (!chk_illegal) begin
                rsp_d.rd_value = csr_rd_data;
                rsp_d.wr_en    = wants_write;
                if (wants_write) begin
                    rsp_d.wr_addr = req_addr;
                    rsp_d.wr_data = merged;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rd_value  = rsp_q.rd_value;
    assign wr_en     = rsp_q.wr_en;
    assign wr_addr   = rsp_q.wr_addr;
    assign wr_data   = rsp_q.wr_data;
    assign illegal   = rsp_q.illegal;

    a_r2_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !wr_en && !illegal));
    a_r3_priv_too_low: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cur_priv < req_addr[9:8])) |=> illegal);
    a_r4_ro_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[11:10] == 2'b11) && (req_op == 2'b01)) |=> illegal);
    a_r7_zero_src_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1] && rs1_is_zero) |=> !wr_en);
    a_r9_unimplemented: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !csr_rd_hit) |=> illegal);
    a_r10_no_write_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && (rd_value == '0)));
    a_r11_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 2'b00)) |=> illegal);
endmodule

// File: tb/csr_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module csr_rmw_unit_tb_top;
    localparam int XLEN = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'b00;
    logic [11:0]      req_addr = '0;
    logic [XLEN-1:0]  rs1_data = '0;
    logic             rs1_is_zero = 1'b0;
    logic [1:0]       cur_priv = 2'd0;
    logic [11:0]      csr_rd_addr;
    logic [XLEN-1:0]  csr_rd_data = '0;
    logic             csr_rd_hit = 1'b0;
    logic             rsp_valid;
    logic [XLEN-1:0]  rd_value;
    logic             wr_en;
    logic [11:0]      wr_addr;
    logic [XLEN-1:0]  wr_data;
    logic             illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    csr_rmw_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .rs1_data(rs1_data), .rs1_is_zero(rs1_is_zero),
        .cur_priv(cur_priv), .csr_rd_addr(csr_rd_addr), .csr_rd_data(csr_rd_data),
        .csr_rd_hit(csr_rd_hit), .rsp_valid(rsp_valid), .rd_value(rd_value),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, let one rising edge pass, then
    // sample at the next falling edge and compare against the model.
    task automatic run_req(input string tag, input logic [1:0] op, input logic [11:0] addr,
                           input logic [31:0] src, input logic zero, input logic [1:0] priv,
                           input logic hit, input logic [31:0] old);
        logic       wr_intent;
        logic       exp_ill;
        logic [31:0] exp_wd;
        wr_intent = (op == 2'b01) || (op[1] && !zero);
        exp_ill   = (op == 2'b00) || !hit || (priv < addr[9:8]) ||
                    ((addr[11:10] == 2'b11) && wr_intent);
        case (op)
            2'b01:   exp_wd = src;
            2'b10:   exp_wd = old | src;
            2'b11:   exp_wd = old & ~src;
            default: exp_wd = old;
        endcase
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; rs1_data = src;
        rs1_is_zero = zero; cur_priv = priv; csr_rd_hit = hit; csr_rd_data = old;
        @(negedge clk);
        req_valid = 1'b0; csr_rd_hit = 1'b0; csr_rd_data = '0;
        chk({tag, " R2 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, exp_ill});
        chk({tag, " R10 wr_en"}, {31'd0, wr_en}, {31'd0, (!exp_ill && wr_intent)});
        chk({tag, " R8 rd_value"}, rd_value, exp_ill ? 32'd0 : old);
        if (!exp_ill && wr_intent) begin
            chk({tag, " R12 wr_addr"}, {20'd0, wr_addr}, {20'd0, addr});
            chk({tag, " R6 wr_data"}, wr_data, exp_wd);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 wr_en", {31'd0, wr_en}, 32'd0);
        chk("R1 illegal", {31'd0, illegal}, 32'd0);
        chk("R1 rd_value", rd_value, 32'd0);
        chk("R1 wr_data", wr_data, 32'd0);
        chk("R1 wr_addr", {20'd0, wr_addr}, 32'd0);
    endtask

    task automatic t_ops();
        run_req("R5 swap M", 2'b01, 12'h340, 32'hA5A5_0F0F, 1'b0, 2'd3, 1'b1, 32'h1234_5678);
        run_req("R6 set M",  2'b10, 12'h340, 32'h0000_FF00, 1'b0, 2'd3, 1'b1, 32'h00F0_0F0F);
        run_req("R6 clr M",  2'b11, 12'h340, 32'h0000_FF00, 1'b0, 2'd3, 1'b1, 32'hFFF0_0F0F);
        run_req("R7 set zero", 2'b10, 12'h340, 32'hFFFF_FFFF, 1'b1, 2'd3, 1'b1, 32'hCAFE_F00D);
        run_req("R7 clr zero", 2'b11, 12'h305, 32'hFFFF_FFFF, 1'b1, 2'd3, 1'b1, 32'h8000_0001);
        run_req("R6 set zero value", 2'b10, 12'h340, 32'h0, 1'b0, 2'd3, 1'b1, 32'h0000_0011);
    endtask

    task automatic t_readonly();
        run_req("R4 ro read U", 2'b10, 12'hC00, 32'h5, 1'b1, 2'd0, 1'b1, 32'h0000_BEEF);
        run_req("R4 ro swap M", 2'b01, 12'hF11, 32'h5, 1'b0, 2'd3, 1'b1, 32'h0000_0042);
        run_req("R4 ro set nz", 2'b10, 12'hC01, 32'h5, 1'b0, 2'd3, 1'b1, 32'h1);
        run_req("R4 ro clr nz", 2'b11, 12'hF14, 32'h0, 1'b0, 2'd3, 1'b1, 32'h7);
    endtask

    task automatic t_priv();
        run_req("R3 S to M", 2'b01, 12'h300, 32'h1, 1'b0, 2'd1, 1'b1, 32'h9);
        run_req("R3 S to S", 2'b01, 12'h100, 32'h3, 1'b0, 2'd1, 1'b1, 32'h9);
        run_req("R3 U to S", 2'b10, 12'h140, 32'h0, 1'b1, 2'd0, 1'b1, 32'h9);
        run_req("R3 M to S", 2'b11, 12'h141, 32'hF, 1'b0, 2'd3, 1'b1, 32'hFF);
        run_req("R3 U to U", 2'b11, 12'h001, 32'h1, 1'b0, 2'd0, 1'b1, 32'h3);
    endtask

    task automatic t_misc();
        run_req("R9 unimpl", 2'b01, 12'h7C0, 32'h1, 1'b0, 2'd3, 1'b0, 32'hDEAD_BEEF);
        run_req("R11 op none", 2'b00, 12'h340, 32'h1, 1'b0, 2'd3, 1'b1, 32'h55);
        @(negedge clk);
        chk("R2 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R2 idle wr_en", {31'd0, wr_en}, 32'd0);
        chk("R2 idle illegal", {31'd0, illegal}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ops();
        t_readonly();
        t_priv();
        t_misc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule